// File: doc/BRIEF.md
# Multi-Core Power Sequencer

This block sequences power for a cluster of up to four processor cores. Software reaches it over a simple synchronous register bus with address, write enable, write data and read data. The read data follows the address within the same cycle. Each core reports a wait-for-interrupt (WFI) indication. The block drives a power-enable line and an active-high reset line for each core.

Software wakes a core by setting that core's bit in a request register. The bit stays set while the power-up runs and clears itself once the core is running, so software polls the register until it reads zero. To put a core to sleep, software first arms standby in that core's control register. The core then drops into standby only at its next WFI. A packed status register reports every core's state. A separate register holds the debug reset-enable bits, which software updates with read-modify-write.

Top module: `cpm_power_ctrl`

## Requirements
- R1: After reset core 0 is running (power enable high, reset low) and every other core is in standby (power enable low, reset high). The request, control and debug registers all read zero.
- R2: A write to the request register at 0x010 sets the request bit of every core whose data bit n is 1. Data bits that are 0 leave pending requests untouched.
- R3: A request for a core in standby makes that core power up. The power-up lasts exactly WAKE_CYCLES cycles, beginning the cycle after the request bit is seen. During it the status code is 1, power enable is high and reset stays high. On the cycle the core reaches run (code 0), reset goes low and its request bit clears.
- R4: A request for a core that is already running clears its request bit on the next clock edge and leaves the core's state unchanged.
- R5: The control register for core n is at 0x100 + 0x10*n and holds a 2-bit value that reads back. Only the value 3 arms standby. An armed core stays running until a cycle in which its WFI input is high. That edge moves it to standby (code 3, power enable low, reset high) and clears its control value to 0.
- R6: A WFI from a running core whose control value is not 3 leaves the core running.
- R7: The status register at 0x040 holds core n's 2-bit state code at bits 4n+1:4n, and all other bits read zero. The codes are 0 for run, 1 for powering up and 3 for standby.
- R8: The debug register at 0x180 stores bit 24 (other-core reset enable), bits 20+n (per-core reset enable) and bit 19 (peripheral reset enable) as read/write bits. Every other bit reads zero.
- R9: Reads of any offset outside the mapped registers return zero. Writes to such offsets, and writes to the status register, change no register.
- R10: If a running core has a pending request in the same cycle that its armed WFI arrives, the request wins. The core stays running, its request bit clears, and its control value stays armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, same cycle |
| core_wfi | input | NUM_CORES | Per-core WFI indication |
| core_pwr_en | output | NUM_CORES | Per-core power enable |
| core_rst | output | NUM_CORES | Per-core reset, active high |

## Verification
A running core can see a pending wake request in the same cycle that its armed WFI arrives. In that case the sequencer has to choose between completing the request and dropping into standby. The bench provokes this by arming core 0 and writing its request bit. It then raises core 0's WFI on the very cycle the request becomes visible. It judges the outcome by reading back status, request and control: the core must still run, its request bit must clear and its arm value must stay 3. A later WFI must then still enter standby.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

    localparam int ADDR_BITS = 12;

    localparam logic [ADDR_BITS-1:0] OFS_WAKE      = 12'h010;
    localparam logic [ADDR_BITS-1:0] OFS_STATUS    = 12'h040;
    localparam logic [ADDR_BITS-1:0] OFS_CTRL_BASE = 12'h100;
    localparam logic [ADDR_BITS-1:0] OFS_CTRL_STEP = 12'h010;
    localparam logic [ADDR_BITS-1:0] OFS_DEBUG     = 12'h180;

    localparam int STATUS_STRIDE = 4;
    localparam int DBG_OTHER_BIT = 24;
    localparam int DBG_CORE_BIT0 = 20;
    localparam int DBG_PERIPH_BIT = 19;

    localparam logic [1:0] ARM_STANDBY = 2'd3;

    typedef enum logic [1:0] {
        CS_RUN  = 2'd0,
        CS_WAKE = 2'd1,
        CS_STBY = 2'd3
    } core_st_e;

    typedef struct packed {
        logic wake_req;
        logic armed;
        logic wfi;
    } core_in_t;

    typedef struct packed {
        core_st_e st;
        logic     pwr_en;
        logic     rst_out;
        logic     wake_done;
        logic     sb_enter;
    } core_out_t;

    function automatic logic [ADDR_BITS-1:0] ctrl_ofs(input int n);
        return OFS_CTRL_BASE + ADDR_BITS'(n) * OFS_CTRL_STEP;
    endfunction

    function automatic logic [31:0] dbg_mask(input int ncores);
        logic [31:0] m;
        m = '0;
        m[DBG_OTHER_BIT]  = 1'b1;
        m[DBG_PERIPH_BIT] = 1'b1;
        for (int i = 0; i < ncores; i++) m[DBG_CORE_BIT0 + i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/cpm_core_seq.sv
module cpm_core_seq
    import cpm_pkg::*;
#(
    parameter int WAKE_CYCLES = 8,
    parameter bit RESET_RUN   = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  core_in_t  ci,
    output core_out_t co
);
    localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
    localparam int CHK_W = CNT_W + 1;

    core_st_e   state_q;
    logic [CNT_W-1:0] cnt_q;
    logic       go_standby;

    assign go_standby = (state_q == CS_RUN) && !ci.wake_req && ci.armed && ci.wfi;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RESET_RUN ? CS_RUN : CS_STBY;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                CS_STBY: begin
                    if (ci.wake_req) begin
                        state_q <= CS_WAKE;
                        cnt_q   <= CNT_W'(WAKE_CYCLES - 1);
                    end
                end
                CS_WAKE: begin
                    if (cnt_q == '0) state_q <= CS_RUN;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                CS_RUN: begin
                    if (go_standby) state_q <= CS_STBY;
                end
                default: state_q <= CS_STBY;
            endcase
        end
    end

    always_comb begin
        co.st        = state_q;
        co.pwr_en    = (state_q != CS_STBY);
        co.rst_out   = (state_q != CS_RUN);
        co.wake_done = ci.wake_req &&
                       ((state_q == CS_RUN) || (state_q == CS_WAKE && cnt_q == '0));
        co.sb_enter  = go_standby;
    end

    // Independent cycle counter used only by the checks below.
    logic [CHK_W-1:0] chk_wake_cnt;
    always_ff @(posedge clk) begin
        if (rst) chk_wake_cnt <= '0;
        else if (state_q == CS_WAKE) chk_wake_cnt <= chk_wake_cnt + 1'b1;
        else chk_wake_cnt <= '0;
    end

    assert_wake_length_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == CS_WAKE && state_q == CS_RUN) |-> chk_wake_cnt == CHK_W'(WAKE_CYCLES));

    assert_standby_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_STBY && !ci.wake_req) |=> state_q == CS_STBY);

    assert_unarmed_wfi_runs_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_RUN && !ci.armed) |=> state_q == CS_RUN);

    assert_request_beats_wfi_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_RUN && ci.wake_req) |=> state_q == CS_RUN);

    assert_waking_never_sleeps_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == CS_WAKE) |=> state_q != CS_STBY);

endmodule

// File: rtl/cpm_regfile.sv
module cpm_regfile
    import cpm_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      we,
    input  logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         rdata,
    input  logic [NUM_CORES-1:0][1:0] core_st,
    input  logic [NUM_CORES-1:0]      wake_done,
    input  logic [NUM_CORES-1:0]      sb_enter,
    output logic [NUM_CORES-1:0]      wake_req,
    output logic [NUM_CORES-1:0]      armed
);
    localparam logic [DATA_W-1:0] DBG_MASK = DATA_W'(dbg_mask(NUM_CORES));

    logic [NUM_CORES-1:0]      wake_q;
    logic [NUM_CORES-1:0][1:0] ctrl_q;
    logic [DATA_W-1:0]         dbg_q;
    logic [DATA_W-1:0]         status_w;

    logic                 wr_wake, wr_dbg;
    logic [NUM_CORES-1:0] wr_ctrl;
    logic                 hit_map;

    always_comb begin
        wr_wake = we && (addr == ADDR_W'(OFS_WAKE));
        wr_dbg  = we && (addr == ADDR_W'(OFS_DEBUG));
        hit_map = (addr == ADDR_W'(OFS_WAKE)) || (addr == ADDR_W'(OFS_DEBUG)) ||
                  (addr == ADDR_W'(OFS_STATUS));
        for (int n = 0; n < NUM_CORES; n++) begin
            wr_ctrl[n] = we && (addr == ADDR_W'(ctrl_ofs(n)));
            if (addr == ADDR_W'(ctrl_ofs(n))) hit_map = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_q <= '0;
            dbg_q  <= '0;
        end else begin
            wake_q <= (wake_q & ~wake_done) | (wr_wake ? wdata[NUM_CORES-1:0] : '0);
            if (wr_dbg) dbg_q <= wdata & DBG_MASK;
        end
    end

    for (genvar n = 0; n < NUM_CORES; n++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (rst)              ctrl_q[n] <= '0;
            else if (wr_ctrl[n])  ctrl_q[n] <= wdata[1:0];
            else if (sb_enter[n]) ctrl_q[n] <= '0;
        end

        assign armed[n] = (ctrl_q[n] == ARM_STANDBY);

        assert_arm_cleared_R5: assert property (@(posedge clk) disable iff (rst)
            (sb_enter[n] && !wr_ctrl[n]) |=> ctrl_q[n] == 2'd0);

        assert_req_clears_only_when_done_R3: assert property (@(posedge clk) disable iff (rst)
            $fell(wake_q[n]) |-> $past(wake_done[n]));

        assert_running_req_clears_R4: assert property (@(posedge clk) disable iff (rst)
            (wake_q[n] && core_st[n] == 2'd0 && !(wr_wake && wdata[n])) |=> !wake_q[n]);
    end

    always_comb begin
        status_w = '0;
        for (int n = 0; n < NUM_CORES; n++)
            status_w[STATUS_STRIDE*n +: 2] = core_st[n];
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_WAKE))        rdata = DATA_W'(wake_q);
        else if (addr == ADDR_W'(OFS_STATUS)) rdata = status_w;
        else if (addr == ADDR_W'(OFS_DEBUG))  rdata = dbg_q;
        for (int n = 0; n < NUM_CORES; n++)
            if (addr == ADDR_W'(ctrl_ofs(n))) rdata = DATA_W'(ctrl_q[n]);
    end

    assign wake_req = wake_q;

    assert_unmapped_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (we && !hit_map) |=> ($stable(dbg_q) && $stable(ctrl_q)));

    assert_debug_mask_R8: assert property (@(posedge clk) disable iff (rst)
        (dbg_q & ~DBG_MASK) == '0);

endmodule

// File: rtl/cpm_power_ctrl.sv
module cpm_power_ctrl
    import cpm_pkg::*;
#(
    parameter int NUM_CORES   = 4,
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int WAKE_CYCLES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_CORES-1:0] core_wfi,
    output logic [NUM_CORES-1:0] core_pwr_en,
    output logic [NUM_CORES-1:0] core_rst
);
    logic [NUM_CORES-1:0][1:0] core_st;
    logic [NUM_CORES-1:0]      wake_done, sb_enter, wake_req, armed;

    cpm_regfile #(
        .NUM_CORES(NUM_CORES),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .core_st  (core_st),
        .wake_done(wake_done),
        .sb_enter (sb_enter),
        .wake_req (wake_req),
        .armed    (armed)
    );

    for (genvar n = 0; n < NUM_CORES; n++) begin : g_core
        core_in_t  ci;
        core_out_t co;

        assign ci.wake_req = wake_req[n];
        assign ci.armed    = armed[n];
        assign ci.wfi      = core_wfi[n];

        cpm_core_seq #(
            .WAKE_CYCLES(WAKE_CYCLES),
            .RESET_RUN  (n == 0)
        ) seq_i (
            .clk(clk),
            .rst(rst),
            .ci (ci),
            .co (co)
        );

        assign core_st[n]     = co.st;
        assign core_pwr_en[n] = co.pwr_en;
        assign core_rst[n]    = co.rst_out;
        assign wake_done[n]   = co.wake_done;
        assign sb_enter[n]    = co.sb_enter;

        assert_reset_until_run_R3: assert property (@(posedge clk) disable iff (rst)
            ($fell(core_rst[n])) |-> $past(core_pwr_en[n]));
    end

endmodule

// File: tb/cpm_power_ctrl_tb.sv
module cpm_power_ctrl_tb_top;
    localparam int N    = 4;
    localparam int WAKE = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [N-1:0] core_wfi;
    logic [N-1:0] core_pwr_en;
    logic [N-1:0] core_rst;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cpm_power_ctrl #(.NUM_CORES(N), .ADDR_W(12), .DATA_W(32), .WAKE_CYCLES(WAKE)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_wfi(core_wfi),
        .core_pwr_en(core_pwr_en), .core_rst(core_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    function automatic logic [31:0] ctrl_addr(input int n);
        return 32'h100 + 32'h10 * n;
    endfunction

    task automatic t_reset();
        check("R1 pwr_en", 32'(core_pwr_en), 32'h1);
        check("R1 core_rst", 32'(core_rst), 32'hE);
        expect_reg("R1 wake reg", 12'h010, 0);
        expect_reg("R1 debug reg", 12'h180, 0);
        for (int n = 0; n < N; n++) expect_reg("R1 ctrl reg", 12'(ctrl_addr(n)), 0);
        expect_reg("R7 status after reset", 12'h040, 32'h0000_3330);
    endtask

    task automatic t_power_up();
        bus_write(12'h010, 32'h4);
        expect_reg("R2 request set", 12'h010, 32'h4);
        expect_reg("R3 not yet waking", 12'h040, 32'h3330);
        step(1);
        expect_reg("R3 waking code", 12'h040, 32'h3130);
        check("R3 pwr_en while waking", 32'(core_pwr_en), 32'h5);
        check("R3 reset held while waking", 32'(core_rst), 32'hE);
        bus_write(12'h010, 32'h0);
        expect_reg("R2 zero write keeps request", 12'h010, 32'h4);
        step(WAKE - 2);
        expect_reg("R3 still waking at last cycle", 12'h040, 32'h3130);
        expect_reg("R3 request pending", 12'h010, 32'h4);
        step(1);
        expect_reg("R3 reached run", 12'h040, 32'h3030);
        expect_reg("R3 request cleared", 12'h010, 32'h0);
        check("R3 reset released", 32'(core_rst), 32'hA);
    endtask

    task automatic t_wake_running();
        bus_write(12'h010, 32'h1);
        expect_reg("R4 request visible", 12'h010, 32'h1);
        step(1);
        expect_reg("R4 request cleared next edge", 12'h010, 32'h0);
        expect_reg("R4 state unchanged", 12'h040, 32'h3030);
    endtask

    task automatic t_standby();
        bus_write(12'(ctrl_addr(2)), 32'h2);
        expect_reg("R5 ctrl readback", 12'(ctrl_addr(2)), 32'h2);
        core_wfi[2] = 1'b1;
        step(1);
        core_wfi[2] = 1'b0;
        expect_reg("R6 unarmed wfi stays run", 12'h040, 32'h3030);
        bus_write(12'(ctrl_addr(2)), 32'h3);
        step(3);
        expect_reg("R5 arm has no immediate effect", 12'h040, 32'h3030);
        check("R5 powered while armed", 32'(core_pwr_en), 32'h5);
        core_wfi[2] = 1'b1;
        step(1);
        core_wfi[2] = 1'b0;
        expect_reg("R5 entered standby", 12'h040, 32'h3330);
        check("R5 pwr_en off", 32'(core_pwr_en), 32'h1);
        check("R5 reset asserted", 32'(core_rst), 32'hE);
        expect_reg("R5 arm cleared", 12'(ctrl_addr(2)), 32'h0);
    endtask

    task automatic t_coincide();
        bus_write(12'(ctrl_addr(0)), 32'h3);
        bus_write(12'h010, 32'h1);
        core_wfi[0] = 1'b1;
        step(1);
        core_wfi[0] = 1'b0;
        expect_reg("R10 core stays run", 12'h040, 32'h3330);
        expect_reg("R10 request cleared", 12'h010, 32'h0);
        expect_reg("R10 arm kept", 12'(ctrl_addr(0)), 32'h3);
        core_wfi[0] = 1'b1;
        step(1);
        core_wfi[0] = 1'b0;
        expect_reg("R10 later wfi sleeps", 12'h040, 32'h3333);
        bus_write(12'h010, 32'h1);
        step(WAKE + 1);
        expect_reg("R3 core0 back to run", 12'h040, 32'h3330);
    endtask

    task automatic t_debug();
        bus_write(12'h180, 32'hFFFF_FFFF);
        expect_reg("R8 writable bits", 12'h180, 32'h01F8_0000);
        bus_write(12'h180, 32'h0010_0000);
        expect_reg("R8 readback", 12'h180, 32'h0010_0000);
    endtask

    task automatic t_unmapped();
        bus_write(12'h020, 32'hFFFF_FFFF);
        bus_write(12'h104, 32'hFFFF_FFFF);
        bus_write(12'h140, 32'hFFFF_FFFF);
        bus_write(12'h040, 32'hFFFF_FFFF);
        expect_reg("R9 read 0x020", 12'h020, 0);
        expect_reg("R9 read 0x104", 12'h104, 0);
        expect_reg("R9 read 0x140", 12'h140, 0);
        expect_reg("R9 debug untouched", 12'h180, 32'h0010_0000);
        expect_reg("R9 wake untouched", 12'h010, 0);
        expect_reg("R9 status untouched", 12'h040, 32'h3330);
        for (int n = 0; n < N; n++) expect_reg("R9 ctrl untouched", 12'(ctrl_addr(n)), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        bus_addr = '0;
        bus_we = 1'b0;
        bus_wdata = '0;
        core_wfi = '0;
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_power_up();
        t_wake_running();
        t_standby();
        t_coincide();
        t_debug();
        t_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule